// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator Slice

This block orders two 8-bit words, P and Q, and raises one of two flags: P above Q or P below Q. When both flags are low, the words are equal. A mode input chooses how the words are read at run time. In one setting they are plain unsigned binaries. In the other they are two's-complement numbers, and the top bit carries the sign.

The P word passes through a holding stage that behaves like a level-sensitive latch. While the enable is high, P reaches the compare directly. While the enable is low, the compare keeps using the last captured value. A synchronous active-low reset clears the held value to zero. The Q word is never held.

Two cascade inputs take the flags of a less significant slice. Slices can therefore be chained, with nothing between them, to order words of any width. In a chain only the most significant slice uses the two's-complement mode, and the least significant slice has its cascade inputs tied low.

Top module: `mag_cmp_slice`

## Requirements
- R1: With `arith_mode`=0 and the compared words different, `gt_out`=1 and `lt_out`=0 exactly when P > Q as unsigned numbers. When P < Q, `lt_out`=1 and `gt_out`=0.
- R2: With `arith_mode`=1, the words are read as two's complement with bit 7 as the sign. So 0x7F is above 0x80, and 0xFF is below 0x00.
- R3: While `p_le`=1, the compare uses the present `p_in`, with no clock cycle of delay.
- R4: While `p_le`=0, the compare uses the `p_in` value sampled at the last rising `clk` edge at which `p_le` was 1. Changes on `p_in` have no effect on the outputs during that time.
- R5: A rising `clk` edge with `rst_n`=0 clears the held P value to 0x00.
- R6: When the compared words differ, `gt_in` and `lt_in` have no effect on the outputs.
- R7: When the compared words are equal, `gt_out` copies `gt_in` and `lt_out` copies `lt_in`. With both cascade inputs low, equality shows as both outputs low.
- R8: When the compared words are equal and both cascade inputs are 1, both outputs are 1.
- R9: Two slices form a 16-bit comparator when the low slice's outputs drive the high slice's cascade inputs. The low slice runs in unsigned mode with its cascade inputs at 0. The high slice's mode sets the reading of the 16-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the P holding register |
| rst_n | input | 1 | Synchronous active-low reset; clears held P |
| p_in | input | 8 | P operand |
| q_in | input | 8 | Q operand, always used directly |
| p_le | input | 1 | P enable: 1 passes P through, 0 holds it |
| arith_mode | input | 1 | 0 unsigned, 1 two's complement |
| gt_in | input | 1 | Above flag from a less significant slice |
| lt_in | input | 1 | Below flag from a less significant slice |
| gt_out | output | 1 | P above Q (or cascaded above) |
| lt_out | output | 1 | P below Q (or cascaded below) |

## Verification
The hardest case to reach is a compare against a held P while `p_in` has since moved to a different value. The stimulus captures one P value with `p_le` high. It then drops `p_le` and drives a new `p_in`, and sets Q equal to the captured value. An output of "equal" can only come from the held word.

The same method exposes the cleared value after reset. The bench resets with `p_le` low and then compares against Q = 0x00 and Q = 0x01. The illegal cascade input pair (both high) is reached in the full P×Q sweep, whose cascade pattern covers all four combinations on equal words.

// File: rtl/magcmp_pkg.sv
// Shared types for the magnitude comparator slice.
// Assumes: nothing beyond standard SystemVerilog.
package magcmp_pkg;
    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_flags_t;
endpackage

// File: rtl/p_hold.sv
// Holding stage for the P operand. It behaves like a transparent latch built
// from a clocked register: with le high the output follows d at once and the
// register tracks d. With le low the output is the value captured at the last
// edge where le was high.
// Assumes: synchronous active-low reset, which clears the held value.
module p_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] held_r;

    // Capture the operand while enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_r <= '0;
        else if (le)
            held_r <= d;
    end

    // Transparent path while enabled, stored word otherwise.
    always_comb begin
        q = le ? d : held_r;
    end
endmodule

// File: rtl/word_order.sv
// Orders two words and returns above/below flags. In signed mode, both sign
// bits are inverted, which maps two's-complement order onto unsigned order.
// Assumes: both operands have the same width, and WIDTH >= 2.
module word_order
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             mode,
    output cmp_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    cmp_mode_e        mode_e;
    logic [WIDTH-1:0] a_biased;
    logic [WIDTH-1:0] b_biased;

    // Bias the sign bit when the signed reading is selected.
    always_comb begin
        mode_e   = cmp_mode_e'(mode);
        a_biased = a;
        b_biased = b;
        if (mode_e == CMP_SIGNED) begin
            a_biased[MSB] = ~a[MSB];
            b_biased[MSB] = ~b[MSB];
        end
    end

    // Unsigned order on the biased words.
    always_comb begin
        flags.gt = (a_biased > b_biased);
        flags.lt = (a_biased < b_biased);
    end
endmodule

// File: rtl/cascade_merge.sv
// Merges local flags with the flags from a less significant slice. A local
// difference decides the result. On local equality the cascade flags pass
// through unchanged, including the illegal pair where both are high.
// Assumes: the local flags are never both high.
module cascade_merge
    import magcmp_pkg::*;
(
    input  cmp_flags_t local_f,
    input  cmp_flags_t casc_f,
    output cmp_flags_t out_f
);
    logic differ;

    // Select the local decision when present, else forward the cascade.
    always_comb begin
        differ = local_f.gt | local_f.lt;
        out_f  = differ ? local_f : casc_f;
    end
endmodule

// File: rtl/mag_cmp_slice.sv
// One cascadable comparator slice. The P operand goes through the holding
// stage, the words are ordered in the chosen mode, and the result is merged
// with the cascade inputs.
// Assumes: in a chain only the top slice uses signed mode, and the lowest
// slice has its cascade inputs tied low.
module mag_cmp_slice
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] p_in,
    input  logic [WIDTH-1:0] q_in,
    input  logic             p_le,
    input  logic             arith_mode,
    input  logic             gt_in,
    input  logic             lt_in,
    output logic             gt_out,
    output logic             lt_out
);
    logic [WIDTH-1:0] p_eff;
    cmp_flags_t       local_f;
    cmp_flags_t       casc_f;
    cmp_flags_t       out_f;

    p_hold #(.WIDTH(WIDTH)) hold_i (
        .clk  (clk),
        .rst_n(rst_n),
        .le   (p_le),
        .d    (p_in),
        .q    (p_eff)
    );

    word_order #(.WIDTH(WIDTH)) order_i (
        .a    (p_eff),
        .b    (q_in),
        .mode (arith_mode),
        .flags(local_f)
    );

    // Pack the cascade inputs into the flag type.
    always_comb begin
        casc_f.gt = gt_in;
        casc_f.lt = lt_in;
    end

    cascade_merge merge_i (
        .local_f(local_f),
        .casc_f (casc_f),
        .out_f  (out_f)
    );

    // Drive the decision outputs.
    always_comb begin
        gt_out = out_f.gt;
        lt_out = out_f.lt;
    end
endmodule

// File: rtl/mag_cmp_slice_chk.sv
// Checker for mag_cmp_slice. It is bound to every instance and watches the
// ports and the effective P word.
// Assumes: synchronous active-low reset.
module mag_cmp_slice_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] p_in,
    input logic [WIDTH-1:0] q_in,
    input logic             p_le,
    input logic             gt_in,
    input logic             lt_in,
    input logic             gt_out,
    input logic             lt_out,
    input logic [WIDTH-1:0] p_eff
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        p_le |-> (p_eff == p_in)); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_le && !$past(p_le) && $past(rst_n)) |-> $stable(p_eff)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !p_le) |-> (p_eff == '0)); // R5

    AST_LOCAL_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (p_eff != q_in) |-> (gt_out != lt_out)); // R6

    AST_EQUAL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_eff == q_in) |-> (gt_out == gt_in && lt_out == lt_in)); // R7

    AST_NO_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(gt_in && lt_in) |-> !(gt_out && lt_out)); // R8
endmodule

bind mag_cmp_slice mag_cmp_slice_chk #(.WIDTH(WIDTH)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .p_in  (p_in),
    .q_in  (q_in),
    .p_le  (p_le),
    .gt_in (gt_in),
    .lt_in (lt_in),
    .gt_out(gt_out),
    .lt_out(lt_out),
    .p_eff (p_eff)
);

// File: tb/mag_cmp_slice_tb_top.sv
// Bench for mag_cmp_slice: a full P x Q sweep in both modes, holding-stage
// and reset checks, and a two-slice 16-bit chain.
module mag_cmp_slice_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] p_in = '0, q_in = '0;
    logic       p_le = 1'b0, arith_mode = 1'b0, gt_in = 1'b0, lt_in = 1'b0;
    logic       gt_out, lt_out;
    logic [7:0] hp_in = '0, hq_in = '0;
    logic       h_mode = 1'b0;
    logic       hgt, hlt;
    int         vectors = 0;
    int         misses = 0;
    int         cycles = 0;

    always #4 clk = ~clk;

    mag_cmp_slice dut_i (
        .clk(clk), .rst_n(rst_n), .p_in(p_in), .q_in(q_in), .p_le(p_le),
        .arith_mode(arith_mode), .gt_in(gt_in), .lt_in(lt_in),
        .gt_out(gt_out), .lt_out(lt_out)
    );

    mag_cmp_slice hi_i (
        .clk(clk), .rst_n(rst_n), .p_in(hp_in), .q_in(hq_in), .p_le(1'b1),
        .arith_mode(h_mode), .gt_in(gt_out), .lt_in(lt_out),
        .gt_out(hgt), .lt_out(hlt)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: {gt,lt} actual=%b expected=%b (p=%h q=%h)",
                     req, act, exp, p_in, q_in);
        end
    endtask

    function automatic logic [1:0] order(input int a, input int b, input logic [1:0] casc);
        if (a > b) return 2'b10;
        if (a < b) return 2'b01;
        return casc;
    endfunction

    function automatic int as_int(input logic [7:0] v, input logic sgn);
        return (sgn && v[7]) ? int'(v) - 256 : int'(v);
    endfunction

    // Watchdog: an expired run counts as a miss and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            misses++;
            $display("FAIL watchdog: cycles actual=%0d expected<=190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // Reset state: P held at zero (R5).
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q_in = 8'h00; #1;
        check("R5 reset equal", {gt_out, lt_out}, 2'b00);
        q_in = 8'h01; #1;
        check("R5 reset below", {gt_out, lt_out}, 2'b01);

        // Full sweep, transparent P, all four cascade pairs (R1 R2 R3 R6 R7 R8).
        p_le = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 256; p++) begin
                for (int q = 0; q < 256; q++) begin
                    logic [1:0] casc, exp;
                    string      req;
                    casc = {p[0] ^ q[1], q[0]};
                    arith_mode = m[0];
                    p_in = p[7:0];
                    q_in = q[7:0];
                    gt_in = casc[1];
                    lt_in = casc[0];
                    #1;
                    exp = order(as_int(p[7:0], m[0]), as_int(q[7:0], m[0]), casc);
                    if (p != q) req = m[0] ? "R2/R6 signed" : "R1/R6 unsigned";
                    else req = (casc == 2'b11) ? "R8 both cascade high" : "R7 equal forward";
                    check(req, {gt_out, lt_out}, exp);
                end
            end
        end

        // Boundary pair 0x7F vs 0x80 in each mode (R1, R2).
        gt_in = 1'b0; lt_in = 1'b0;
        p_in = 8'h7F; q_in = 8'h80; arith_mode = 1'b0; #1;
        check("R1 7F vs 80", {gt_out, lt_out}, 2'b01);
        arith_mode = 1'b1; #1;
        check("R2 7F vs 80", {gt_out, lt_out}, 2'b10);
        arith_mode = 1'b0;

        // Holding behaviour (R3, R4).
        @(negedge clk);
        p_le = 1'b1; p_in = 8'h55; q_in = 8'h55;
        #1 check("R3 transparent", {gt_out, lt_out}, 2'b00);
        @(negedge clk);
        p_le = 1'b0; p_in = 8'hAA; #1;
        check("R4 hold ignores new P", {gt_out, lt_out}, 2'b00);
        repeat (3) @(negedge clk);
        p_in = 8'h00; #1;
        check("R4 hold after cycles", {gt_out, lt_out}, 2'b00);
        q_in = 8'h56; #1;
        check("R4 held below Q", {gt_out, lt_out}, 2'b01);
        p_in = 8'hAA; p_le = 1'b1; #1;
        check("R3 reopen transparent", {gt_out, lt_out}, 2'b10);

        // Reset clears the held value (R5).
        @(negedge clk);
        p_le = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; q_in = 8'h00; #1;
        check("R5 cleared equal", {gt_out, lt_out}, 2'b00);
        q_in = 8'h01; #1;
        check("R5 cleared below", {gt_out, lt_out}, 2'b01);

        // 16-bit chain (R9).
        p_le = 1'b1; arith_mode = 1'b0; gt_in = 1'b0; lt_in = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] a, b;
            logic [1:0]  exp;
            int          ai, bi;
            a = 16'($urandom);
            b = (k % 4 == 0) ? a : (k % 4 == 1) ? {a[15:8], 8'($urandom)} : 16'($urandom);
            if (k == 1) begin a = 16'h7FFF; b = 16'h8000; end
            h_mode = k[0] ^ k[3];
            {hp_in, p_in} = a;
            {hq_in, q_in} = b;
            #1;
            ai = h_mode ? int'($signed(a)) : int'(a);
            bi = h_mode ? int'($signed(b)) : int'(b);
            exp = order(ai, bi, 2'b00);
            vectors++;
            if ({hgt, hlt} !== exp) begin
                misses++;
                $display("FAIL R9 chain: {gt,lt} actual=%b expected=%b (a=%h b=%h mode=%b)",
                         {hgt, hlt}, exp, a, b, h_mode);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule